// File: doc/BRIEF.md
# NAPOT-Aware Translation Lookaside Buffer

A small fully associative address translation cache for a 64-bit core with three-level, 39-bit virtual paging. A page table walker writes leaf entries through a fill port, giving the 64-bit leaf PTE, the 27-bit virtual page number, the address space identifier and the page level (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB). The lookup port takes a virtual address and ASID and answers combinationally, in the same cycle, with a hit flag, the physical page number and the low eight PTE flag bits.

Apart from ordinary pages and superpages, an entry can hold a 64 KiB naturally aligned power-of-two page. Such an entry stores the PTE as it arrived, plus a one-bit NAPOT marker. A lookup against a marked entry ignores the four lowest VPN bits. The returned PPN takes its low nibble from the virtual address, so sixteen contiguous 4 KiB virtual pages map onto sixteen contiguous physical pages through a single entry. A fill that would overlap a live entry of the same address space replaces that entry, so a lookup never matches more than one entry. Three flush inputs invalidate entries: one by ASID, one by non-global scope, and one for everything.

Top module: `napot_tlb`

## Requirements
- R1: After reset no lookup hits and `fill_err_o` is low.
- R2: A level-0 entry without the NAPOT marker hits only when the lookup VPN equals its VPN and the ASID matches. It returns PTE bits [53:10] as the PPN and PTE bits [7:0] as `lookup_flags_o`.
- R3: A level-0 fill whose PTE has bit 63 (N) set and PTE bits [13:10] (PPN[3:0]) equal to 4'b1000 creates a NAPOT entry. Every lookup VPN that agrees with the fill VPN in bits [26:4] hits it, whatever the fill VPN's low nibble, and VPNs outside that 16-page group miss.
- R4: On a NAPOT hit, the PPN is the stored PPN with bits [3:0] replaced by virtual address bits [15:12].
- R5: A fill with N set and PPN[3:0] not equal to 4'b1000 raises `fill_err_o` in the cycle the fill is presented, and writes no entry.
- R6: Level-1 entries ignore VPN[8:0], and level-2 (or level-3) entries ignore VPN[17:0]. The PPN bits below the page size come from the virtual address. N with a valid encoding has no further effect at these levels.
- R7: An entry whose PTE bit 5 (G) is set hits for any lookup ASID.
- R8: `flush_i` with `flush_asid_i` equal to zero invalidates every non-global entry and keeps global ones.
- R9: `flush_i` with a nonzero `flush_asid_i` invalidates only non-global entries of that ASID.
- R10: `flush_all_i` invalidates every entry. Any flush takes priority over a fill in the same cycle, and that fill is dropped.
- R11: A fill whose range overlaps a valid entry of the same ASID, or where either entry is global, replaces it, so at most one entry matches any lookup.
- R12: A fill with no overlap takes the lowest-numbered invalid entry. When all entries are valid, it takes the entry at a round-robin pointer. The pointer starts at 0 and advances by one only when it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | 27 | VPN of the filled translation |
| fill_asid_i | input | ASID_W | ASID of the fill |
| fill_level_i | input | 2 | Page level: 0 = 4 KiB, 1 = 2 MiB, 2/3 = 1 GiB |
| fill_pte_i | input | 64 | Leaf PTE from the walker |
| fill_err_o | output | 1 | Reserved NAPOT encoding, fill rejected |
| lookup_vaddr_i | input | 39 | Virtual address to translate |
| lookup_asid_i | input | ASID_W | ASID of the lookup |
| lookup_hit_o | output | 1 | A valid entry matches |
| lookup_ppn_o | output | 44 | Translated PPN |
| lookup_flags_o | output | 8 | PTE bits [7:0] of the matching entry |
| flush_i | input | 1 | Scoped flush request |
| flush_asid_i | input | ASID_W | Flush scope; zero means all non-global |
| flush_all_i | input | 1 | Invalidate all entries |

## Verification
A wrong NAPOT marker or mask shows up in the same cycle as the lookup. Neighbouring VPNs in the 16-page group miss when they should hit, or a VPN outside the group hits. The PPN low nibble also fails to follow the virtual address. A faulty overlap or victim choice shows up as a stale translation, or as a translation missing after the next fill, so the bench looks at every affected address right after each fill. Faulty flush scope shows up on the first lookup after the flush cycle, and a fill that should have been rejected shows up on the lookup that follows it.

// File: rtl/napot_tlb_pkg.sv
package napot_tlb_pkg;
  localparam int unsigned VPN_SEG_W   = 9;
  localparam int unsigned PT_LEVELS   = 3;
  localparam int unsigned VPN_W       = VPN_SEG_W * PT_LEVELS;
  localparam int unsigned PG_OFF_W    = 12;
  localparam int unsigned VA_W        = VPN_W + PG_OFF_W;
  localparam int unsigned PPN_W       = 44;
  localparam int unsigned PTE_W       = 64;
  localparam int unsigned FLAG_W      = 8;
  localparam int unsigned NAPOT_W     = 4;
  localparam int unsigned PTE_N_BIT   = 63;
  localparam int unsigned PTE_G_BIT   = 5;
  localparam int unsigned PTE_PPN_LSB = 10;
  localparam logic [NAPOT_W-1:0] NAPOT_64K_CODE = 4'b1000;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [1:0]       level;
    logic             napot;
    logic [PTE_W-1:0] pte;
  } tlb_entry_t;

  // VPN bits that take part in the compare
  function automatic logic [VPN_W-1:0] care_mask(input logic [1:0] level, input logic napot);
    logic [VPN_W-1:0] m;
    m = '1;
    if (level >= 2'd2)      m[2*VPN_SEG_W-1:0] = '0;
    else if (level == 2'd1) m[VPN_SEG_W-1:0]   = '0;
    else if (napot)         m[NAPOT_W-1:0]     = '0;
    return m;
  endfunction
endpackage

// File: rtl/napot_tlb_match.sv
module napot_tlb_match
  import napot_tlb_pkg::*;
#(
  parameter int unsigned ASID_W = 16
) (
  input  tlb_entry_t        ent_i,
  input  logic              valid_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [VPN_W-1:0]  fill_mask_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_global_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              overlap_o
);
  logic [VPN_W-1:0] mask;
  logic [PPN_W-1:0] pmask, stored_ppn;
  logic             glob;

  assign mask       = care_mask(ent_i.level, ent_i.napot);
  assign pmask      = {{(PPN_W-VPN_W){1'b1}}, mask};
  assign stored_ppn = ent_i.pte[PTE_PPN_LSB +: PPN_W];
  assign glob       = ent_i.pte[PTE_G_BIT];

  assign hit_o = valid_i && (glob || ent_asid_i == lk_asid_i) &&
                 (((ent_i.vpn ^ lk_vpn_i) & mask) == '0);
  // bits below the page size come from the virtual address
  assign ppn_o = (stored_ppn & pmask) | ({{(PPN_W-VPN_W){1'b0}}, lk_vpn_i} & ~pmask);

  assign overlap_o = valid_i && (glob || fill_global_i || ent_asid_i == fill_asid_i) &&
                     (((ent_i.vpn ^ fill_vpn_i) & mask & fill_mask_i) == '0);
endmodule

// File: rtl/napot_tlb_victim.sv
module napot_tlb_victim #(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  logic [NUM_ENTRIES-1:0] overlap_i,
  input  logic                   alloc_i,
  output logic [NUM_ENTRIES-1:0] sel_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [IDX_W-1:0] rr_q;
  logic             from_rr;

  always_comb begin
    logic found;
    sel_o   = '0;
    from_rr = 1'b0;
    found   = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && overlap_i[i]) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && !valid_i[i]) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    if (!found) begin
      sel_o[rr_q] = 1'b1;
      from_rr     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && from_rr)
      rr_q <= (rr_q == IDX_W'(NUM_ENTRIES-1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/napot_tlb.sv
module napot_tlb
  import napot_tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ASID_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [26:0]       fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [1:0]        fill_level_i,
  input  logic [63:0]       fill_pte_i,
  output logic              fill_err_o,
  input  logic [38:0]       lookup_vaddr_i,
  input  logic [ASID_W-1:0] lookup_asid_i,
  output logic              lookup_hit_o,
  output logic [43:0]       lookup_ppn_o,
  output logic [7:0]        lookup_flags_o,
  input  logic              flush_i,
  input  logic [ASID_W-1:0] flush_asid_i,
  input  logic              flush_all_i
);
  tlb_entry_t               ent_q  [NUM_ENTRIES];
  logic [ASID_W-1:0]        asid_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]   valid_q;
  logic [NUM_ENTRIES-1:0]   match_vec, overlap_vec, sel_vec, napot_vec;
  logic [PPN_W-1:0]         ppn_arr [NUM_ENTRIES];
  logic [VPN_W-1:0]         lk_vpn, fill_mask;
  logic                     fill_n, fill_napot, fill_ok, hit_napot;

  assign lk_vpn     = lookup_vaddr_i[VA_W-1:PG_OFF_W];
  assign fill_n     = fill_pte_i[PTE_N_BIT];
  assign fill_err_o = fill_valid_i && fill_n &&
                      (fill_pte_i[PTE_PPN_LSB +: NAPOT_W] != NAPOT_64K_CODE);
  assign fill_napot = fill_n && (fill_level_i == 2'd0);
  assign fill_mask  = care_mask(fill_level_i, fill_napot);
  assign fill_ok    = fill_valid_i && !fill_err_o && !flush_i && !flush_all_i;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    napot_tlb_match #(.ASID_W(ASID_W)) u_match (
      .ent_i         (ent_q[g]),
      .valid_i       (valid_q[g]),
      .ent_asid_i    (asid_q[g]),
      .lk_vpn_i      (lk_vpn),
      .lk_asid_i     (lookup_asid_i),
      .fill_vpn_i    (fill_vpn_i),
      .fill_mask_i   (fill_mask),
      .fill_asid_i   (fill_asid_i),
      .fill_global_i (fill_pte_i[PTE_G_BIT]),
      .hit_o         (match_vec[g]),
      .ppn_o         (ppn_arr[g]),
      .overlap_o     (overlap_vec[g])
    );
    assign napot_vec[g] = ent_q[g].napot;
  end

  napot_tlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_q),
    .overlap_i (overlap_vec),
    .alloc_i   (fill_ok),
    .sel_o     (sel_vec)
  );

  // at most one match by construction of fills: OR-mux
  always_comb begin
    lookup_ppn_o   = '0;
    lookup_flags_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (match_vec[i]) begin
        lookup_ppn_o   = lookup_ppn_o | ppn_arr[i];
        lookup_flags_o = lookup_flags_o | ent_q[i].pte[FLAG_W-1:0];
      end
    end
  end
  assign lookup_hit_o = |match_vec;
  assign hit_napot    = |(match_vec & napot_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_q[i]  <= '0;
        asid_q[i] <= '0;
      end
    end else if (flush_all_i) begin
      valid_q <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < NUM_ENTRIES; i++)
        if (valid_q[i] && !ent_q[i].pte[PTE_G_BIT] &&
            (flush_asid_i == '0 || asid_q[i] == flush_asid_i))
          valid_q[i] <= 1'b0;
    end else if (fill_ok) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (sel_vec[i]) begin
          valid_q[i]   <= 1'b1;
          ent_q[i]     <= '{vpn: fill_vpn_i, level: fill_level_i, napot: fill_napot, pte: fill_pte_i};
          asid_q[i]    <= fill_asid_i;
        end else if (overlap_vec[i]) begin
          valid_q[i]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/napot_tlb_chk.sv
module napot_tlb_chk #(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   fill_valid_i,
  input logic                   fill_err_o,
  input logic                   flush_i,
  input logic                   flush_all_i,
  input logic                   lookup_hit_o,
  input logic [43:0]            lookup_ppn_o,
  input logic [38:0]            lookup_vaddr_i,
  input logic [NUM_ENTRIES-1:0] match_vec,
  input logic [NUM_ENTRIES-1:0] valid_q,
  input logic                   hit_napot
);
  // R11
  one_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  // R5
  err_needs_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> fill_valid_i);

  // R5
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_err_o && !flush_i && !flush_all_i) |=> $stable(valid_q));

  // R10
  flush_all_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q == '0 && !lookup_hit_o));

  // R4
  napot_low_ppn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_hit_o && hit_napot) |-> (lookup_ppn_o[3:0] == lookup_vaddr_i[15:12]));
endmodule

bind napot_tlb napot_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fill_valid_i   (fill_valid_i),
  .fill_err_o     (fill_err_o),
  .flush_i        (flush_i),
  .flush_all_i    (flush_all_i),
  .lookup_hit_o   (lookup_hit_o),
  .lookup_ppn_o   (lookup_ppn_o),
  .lookup_vaddr_i (lookup_vaddr_i),
  .match_vec      (match_vec),
  .valid_q        (valid_q),
  .hit_napot      (hit_napot)
);

// File: tb/napot_tlb_test.sv
`timescale 1ns/1ps
module napot_tlb_test;
  localparam int unsigned ASID_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fill_valid_i = 1'b0;
  logic [26:0]       fill_vpn_i = '0;
  logic [ASID_W-1:0] fill_asid_i = '0;
  logic [1:0]        fill_level_i = '0;
  logic [63:0]       fill_pte_i = '0;
  logic              fill_err_o;
  logic [38:0]       lookup_vaddr_i = '0;
  logic [ASID_W-1:0] lookup_asid_i = '0;
  logic              lookup_hit_o;
  logic [43:0]       lookup_ppn_o;
  logic [7:0]        lookup_flags_o;
  logic              flush_i = 1'b0;
  logic [ASID_W-1:0] flush_asid_i = '0;
  logic              flush_all_i = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  napot_tlb #(.NUM_ENTRIES(8), .ASID_W(ASID_W)) uut (.*);

  function automatic logic [63:0] mk_pte(input logic n, input logic [43:0] ppn, input logic g);
    return {n, 9'h0, ppn, 2'b00, (g ? 8'hEF : 8'hCF)};
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [26:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic [1:0] lvl, input logic [63:0] pte);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_asid_i = asid;
    fill_level_i = lvl;  fill_pte_i = pte;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic flush(input logic all, input logic [ASID_W-1:0] asid);
    @(negedge clk_i);
    flush_all_i = all; flush_i = ~all; flush_asid_i = asid;
    @(negedge clk_i);
    flush_all_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic look(input string req, input logic [26:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic exp_hit, input logic [43:0] exp_ppn);
    @(negedge clk_i);
    lookup_vaddr_i = {vpn, 12'h5A4}; lookup_asid_i = asid;
    #1;
    check(req, 64'(lookup_hit_o), 64'(exp_hit));
    if (exp_hit) check(req, 64'(lookup_ppn_o), 64'(exp_ppn));
  endtask

  task automatic t_reset;
    look("R1", 27'h0, 16'h0, 1'b0, '0);
    look("R1", 27'h7FF_FFFF, 16'h3, 1'b0, '0);
    check("R1", 64'(fill_err_o), 64'h0);
  endtask

  task automatic t_plain;
    fill(27'h0012345, 16'h1, 2'd0, mk_pte(1'b0, 44'h00ABCDE1, 1'b0));
    look("R2", 27'h0012345, 16'h1, 1'b1, 44'h00ABCDE1);
    check("R2", 64'(lookup_flags_o), 64'hCF);
    look("R2", 27'h0012344, 16'h1, 1'b0, '0);
    look("R2", 27'h0012346, 16'h1, 1'b0, '0);
    look("R2", 27'h0012345, 16'h2, 1'b0, '0);
    flush(1'b1, '0);
  endtask

  task automatic t_napot;
    // unaligned fill VPN, NAPOT encoding in PPN[3:0]
    fill(27'h0045675, 16'h4, 2'd0, mk_pte(1'b1, 44'h0000ABC8, 1'b0));
    for (int k = 0; k < 16; k++)
      look("R3_R4", 27'h0045670 + 27'(k), 16'h4, 1'b1, {40'h0000ABC, 4'(k)});
    look("R3", 27'h0045680, 16'h4, 1'b0, '0);
    look("R3", 27'h004566F, 16'h4, 1'b0, '0);
    flush(1'b1, '0);
  endtask

  task automatic t_reserved;
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 27'h0033330; fill_asid_i = 16'h1;
    fill_level_i = 2'd0; fill_pte_i = mk_pte(1'b1, 44'h00001234, 1'b0);
    #1 check("R5", 64'(fill_err_o), 64'h1);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    #1 check("R5", 64'(fill_err_o), 64'h0);
    look("R5", 27'h0033330, 16'h1, 1'b0, '0);
    look("R5", 27'h0033334, 16'h1, 1'b0, '0);
    // valid encoding raises no error
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_pte_i = mk_pte(1'b1, 44'h00001238, 1'b0);
    #1 check("R5", 64'(fill_err_o), 64'h0);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    look("R5", 27'h0033334, 16'h1, 1'b1, 44'h00001234);
    flush(1'b1, '0);
  endtask

  task automatic t_super;
    fill({18'h00123, 9'h000}, 16'h2, 2'd1, mk_pte(1'b1, 44'h00089A08, 1'b0));
    look("R6", {18'h00123, 9'h1F3}, 16'h2, 1'b1, 44'h00089BF3);
    look("R6", {18'h00124, 9'h000}, 16'h2, 1'b0, '0);
    fill({9'h005, 18'h00000}, 16'h2, 2'd2, mk_pte(1'b0, 44'h000C0000, 1'b0));
    look("R6", {9'h005, 18'h2ABCD}, 16'h2, 1'b1, 44'h000EABCD);
    look("R6", {9'h006, 18'h00000}, 16'h2, 1'b0, '0);
    flush(1'b1, '0);
  endtask

  task automatic t_flush;
    fill(27'h0000100, 16'h1, 2'd0, mk_pte(1'b0, 44'h111, 1'b0));
    fill(27'h0000100, 16'h2, 2'd0, mk_pte(1'b0, 44'h222, 1'b0));
    fill(27'h0000200, 16'h7, 2'd0, mk_pte(1'b0, 44'h333, 1'b1));
    look("R7", 27'h0000200, 16'h9, 1'b1, 44'h333);
    check("R7", 64'(lookup_flags_o), 64'hEF);
    flush(1'b0, 16'h1);
    look("R9", 27'h0000100, 16'h1, 1'b0, '0);
    look("R9", 27'h0000100, 16'h2, 1'b1, 44'h222);
    look("R9", 27'h0000200, 16'h2, 1'b1, 44'h333);
    flush(1'b0, 16'h0);
    look("R8", 27'h0000100, 16'h2, 1'b0, '0);
    look("R8", 27'h0000200, 16'h5, 1'b1, 44'h333);
    flush(1'b1, '0);
    look("R10", 27'h0000200, 16'h5, 1'b0, '0);
    // fill in a flush cycle is dropped
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 27'h0000300; fill_asid_i = 16'h1;
    fill_level_i = 2'd0; fill_pte_i = mk_pte(1'b0, 44'h444, 1'b0);
    flush_all_i = 1'b1;
    @(negedge clk_i);
    fill_valid_i = 1'b0; flush_all_i = 1'b0;
    look("R10", 27'h0000300, 16'h1, 1'b0, '0);
  endtask

  task automatic t_overlap;
    fill(27'h0001235, 16'h1, 2'd0, mk_pte(1'b0, 44'h5551, 1'b0));
    fill(27'h0001235, 16'h2, 2'd0, mk_pte(1'b0, 44'h6662, 1'b0));
    fill(27'h0001230, 16'h1, 2'd0, mk_pte(1'b1, 44'h0ABC8, 1'b0));
    look("R11", 27'h0001235, 16'h1, 1'b1, 44'h0ABC5);
    look("R11", 27'h0001235, 16'h2, 1'b1, 44'h6662);
    look("R11", 27'h000123A, 16'h1, 1'b1, 44'h0ABCA);
    // a 4 KiB fill inside the NAPOT range replaces it
    fill(27'h0001233, 16'h1, 2'd0, mk_pte(1'b0, 44'h7773, 1'b0));
    look("R11", 27'h0001233, 16'h1, 1'b1, 44'h7773);
    look("R11", 27'h0001235, 16'h1, 1'b0, '0);
    flush(1'b1, '0);
  endtask

  task automatic t_replace;
    for (int k = 0; k < 8; k++)
      fill(27'h0010000 + 27'(k << 4), 16'h1, 2'd0, mk_pte(1'b0, 44'h100 + 44'(k), 1'b0));
    for (int k = 0; k < 8; k++)
      look("R12", 27'h0010000 + 27'(k << 4), 16'h1, 1'b1, 44'h100 + 44'(k));
    fill(27'h0020000, 16'h1, 2'd0, mk_pte(1'b0, 44'h200, 1'b0));
    look("R12", 27'h0010000, 16'h1, 1'b0, '0);
    look("R12", 27'h0010010, 16'h1, 1'b1, 44'h101);
    look("R12", 27'h0020000, 16'h1, 1'b1, 44'h200);
    fill(27'h0020010, 16'h1, 2'd0, mk_pte(1'b0, 44'h201, 1'b0));
    look("R12", 27'h0010010, 16'h1, 1'b0, '0);
    look("R12", 27'h0010020, 16'h1, 1'b1, 44'h102);
    // freed slot is preferred over the pointer
    flush(1'b1, '0);
    fill(27'h0030000, 16'h1, 2'd0, mk_pte(1'b0, 44'h300, 1'b0));
    look("R12", 27'h0030000, 16'h1, 1'b1, 44'h300);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_plain;
    t_napot;
    t_reserved;
    t_super;
    t_flush;
    t_overlap;
    t_replace;
    done = 1'b1;
    report;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report;
    end
  end
endmodule